// File: doc/BRIEF.md
# Timed-Access Write Protection Unit

This unit sits beside a CPU's special-function-register write bus. It keeps selected register bits from being changed by a stray or runaway store. Software unlocks the guarded bits with a two-byte key, written in a fixed order to one dedicated key register. A correct key opens a short write window. A write that targets a guarded bit succeeds only while that window is open. Writes to unguarded registers are never held back.

Each cycle the register file presents its write strobe, address and data, and a flag that says whether the target is guarded. The unit answers in the same cycle with a write-allowed qualifier, which gates the register update. It also reports whether the window is open. The unit does not decide which bits are guarded, and it holds no register contents.

Top module: `ta_guard`

## Requirements
- R1: During and directly after reset the window is closed, no key step is pending, and a guarded write is refused.
- R2: A write with the guard flag low is allowed in the same cycle, whether the window is open or closed.
- R3: A write of 8'hAA to address 8'hC7, followed by a write of 8'h55 to 8'hC7 as the next bus write, drives the window-open output high for exactly the three cycles after the 8'h55 write cycle.
- R4: A guarded write made while the window is open is allowed in that same cycle, and the window is closed from the next cycle on.
- R5: A guarded write made while the window is closed is refused.
- R6: After the 8'hAA step, the next bus write returns the sequencer to idle if it is anything other than 8'h55 (or 8'hAA) to 8'hC7. This holds whatever its address or data. A later 8'h55 to 8'hC7 then opens no window.
- R7: A write of 8'hAA to 8'hC7 at any time closes an open window from the next cycle and makes the sequence wait for 8'h55.
- R8: A write of 8'h55 to 8'hC7 with no pending 8'hAA step opens no window.
- R9: The write-allowed output is low in every cycle whose write strobe is low.
- R10: Cycles without a bus write, between the 8'hAA step and the 8'h55 step, do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register-bus write strobe |
| wr_addr | input | 8 | Register-bus write address |
| wr_data | input | 8 | Register-bus write data |
| wr_prot | input | 1 | The current write targets a guarded bit |
| wr_allow | output | 1 | The current write may update its target |
| win_open | output | 1 | The write window is open in this cycle |

## Verification
The write-allowed qualifier is combinational, so it is due in the same cycle as the write that it gates. The window output moves one clock edge after the write that opens or closes it. After the 8'h55 write it stays high for three cycles, then falls. The bench drives inputs on the falling edge, compares both outputs with its model shortly afterwards, and only then advances the model at the rising edge. Each comparison therefore checks the cycle that the requirement names.

// File: rtl/ta_pkg.sv
package ta_pkg;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

  // Window counter update: restart beats everything, then a fresh unlock,
  // then consumption by a guarded write, then the plain countdown.
  function automatic logic [7:0] ta_next_count(
    input logic [7:0] cnt,
    input logic       kill,
    input logic       load,
    input logic       used,
    input logic [7:0] max_cnt
  );
    if (kill)            return 8'd0;
    else if (load)       return max_cnt;
    else if (used)       return 8'd0;
    else if (cnt != 8'd0) return cnt - 8'd1;
    else                 return 8'd0;
  endfunction

  // Write qualifier: unguarded writes pass, guarded ones need the window.
  function automatic logic ta_grant(
    input logic en,
    input logic prot,
    input logic open_now
  );
    return en && (!prot || open_now);
  endfunction

endpackage

// File: rtl/ta_key_seq.sv
module ta_key_seq
  import ta_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              restart_evt,
  output logic              unlock_evt
);

  key_state_e state_q, state_d;
  logic       key_wr;

  assign key_wr      = wr_en && (wr_addr == KEY_ADDR);
  assign restart_evt = key_wr && (wr_data == KEY_FIRST);
  assign unlock_evt  = (state_q == KS_ARMED) && key_wr && (wr_data == KEY_SECOND);

  always_comb begin
    state_d = state_q;
    if (restart_evt)  state_d = KS_ARMED;
    else if (wr_en)   state_d = KS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ta_win_timer.sv
module ta_win_timer
  import ta_pkg::*;
#(
  parameter int WIN_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic load,
  input  logic used,
  output logic open_now
);

  localparam logic [7:0] MAX_CNT = 8'(WIN_CYCLES);

  logic [7:0] cnt_q;

  assign open_now = (cnt_q != 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= 8'd0;
    else        cnt_q <= ta_next_count(cnt_q, kill, load, used, MAX_CNT);
  end

endmodule

// File: rtl/ta_guard.sv
module ta_guard
  import ta_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int WIN_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_prot,
  output logic              wr_allow,
  output logic              win_open
);

  logic restart_evt;
  logic unlock_evt;
  logic prot_used;

  ta_key_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .restart_evt (restart_evt),
    .unlock_evt  (unlock_evt)
  );

  assign prot_used = wr_en && wr_prot && win_open;

  ta_win_timer #(
    .WIN_CYCLES (WIN_CYCLES)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .kill     (restart_evt),
    .load     (unlock_evt),
    .used     (prot_used),
    .open_now (win_open)
  );

  assign wr_allow = ta_grant(wr_en, wr_prot, win_open);

endmodule

// File: rtl/ta_guard_chk.sv
module ta_guard_chk #(
  parameter int WIN_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_prot,
  input logic wr_allow,
  input logic win_open,
  input logic restart_evt,
  input logic unlock_evt
);

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_len <= 0;
    else if (win_open)  run_len <= run_len + 1;
    else                run_len <= 0;
  end

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_allow);

  // R2
  unprot_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_prot) |-> wr_allow);

  // R5
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_prot && !win_open) |-> !wr_allow);

  // R4
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_prot && win_open) |=> !win_open);

  // R3
  unlock_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_evt |=> win_open);

  // R3
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (run_len < WIN_CYCLES));

  // R7
  restart_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> !win_open);

  // R8
  open_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(unlock_evt));

endmodule

bind ta_guard ta_guard_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_prot     (wr_prot),
  .wr_allow    (wr_allow),
  .win_open    (win_open),
  .restart_evt (restart_evt),
  .unlock_evt  (unlock_evt)
);

// File: tb/tb_ta_guard.sv
`timescale 1ns/1ps
module tb_ta_guard;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       wr_prot;
  logic       wr_allow;
  logic       win_open;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  bit armed   = 1'b0;
  int left    = 0;

  always #5 clk = ~clk;

  ta_guard dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_prot  (wr_prot),
    .wr_allow (wr_allow),
    .win_open (win_open)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One bus cycle: drive at falling edge, compare, then advance model at rising edge.
  task automatic cyc(input string tag, input logic en, input logic [7:0] a,
                     input logic [7:0] d, input logic p);
    bit is_first, is_unlock;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d; wr_prot = p;
    #1;
    check(tag, "win_open", win_open, left > 0);
    check(tag, "wr_allow", wr_allow, en && (!p || left > 0));
    @(posedge clk);
    is_first  = en && a == 8'hC7 && d == 8'hAA;
    is_unlock = armed && en && a == 8'hC7 && d == 8'h55;
    if (is_first)                  left = 0;
    else if (is_unlock)            left = 3;
    else if (en && p && left > 0)  left = 0;
    else if (left > 0)             left = left - 1;
    if (is_first)    armed = 1'b1;
    else if (en)     armed = 1'b0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic key(input string tag, input logic [7:0] d);
    cyc(tag, 1'b1, 8'hC7, d, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00; wr_prot = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "win_open in reset", win_open, 1'b0);
    rst_n = 1'b1;
    cyc("R1", 1'b1, 8'h90, 8'h01, 1'b1);       // guarded write right after reset
    cyc("R8", 1'b1, 8'hC7, 8'h55, 1'b0);       // R1: no pending step; R8 second key alone
    idle("R8", 4);
    // R2 unguarded pass with window closed
    cyc("R2", 1'b1, 8'h80, 8'h3C, 1'b0);
    // R3 full window and expiry
    key("R3", 8'hAA); key("R3", 8'h55);
    cyc("R2", 1'b1, 8'h81, 8'h11, 1'b0);       // unguarded inside window
    idle("R3", 4);
    cyc("R5", 1'b1, 8'h90, 8'h02, 1'b1);       // after expiry
    // R4 one guarded write then closed
    key("R4", 8'hAA); key("R4", 8'h55);
    idle("R4", 1);
    cyc("R9", 1'b0, 8'h90, 8'h00, 1'b1);       // strobe low, guard high, window open
    cyc("R4", 1'b1, 8'h90, 8'h03, 1'b1);       // allowed, third cycle
    cyc("R4", 1'b1, 8'h90, 8'h04, 1'b1);       // refused
    // R6 aborted sequences
    key("R6", 8'hAA); cyc("R6", 1'b1, 8'h85, 8'h55, 1'b0); key("R6", 8'h55);
    idle("R6", 2);
    key("R6", 8'hAA); key("R6", 8'h12); key("R6", 8'h55);
    idle("R6", 2);
    // R7 restart closes an open window, then completes
    key("R7", 8'hAA); key("R7", 8'h55); idle("R7", 1);
    key("R7", 8'hAA); idle("R7", 1); key("R7", 8'h55);
    cyc("R7", 1'b1, 8'h90, 8'h05, 1'b1);
    // R10 gaps between key steps
    key("R10", 8'hAA); idle("R10", 3); key("R10", 8'h55); idle("R10", 4);
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0, 1:    key("R3", 8'hAA);
        2, 3:    key("R3", 8'h55);
        4:       key("R6", 8'($urandom));
        5, 6:    cyc("R4", 1'b1, 8'h90, 8'($urandom), 1'b1);
        7:       cyc("R2", 1'b1, 8'h88, 8'($urandom), 1'b0);
        default: cyc("R9", 1'b0, 8'($urandom), 8'($urandom), 1'($urandom));
      endcase
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule